// File: doc/BRIEF.md
# Dual-Encoding Interrupt Route Controller

This block collects 256 level-sensitive interrupt request lines and routes each one to a target CPU and a CPU interrupt pin. Every vector has an enable bit and an 8-bit route byte. Every group of 32 vectors shares a 4-bit pin selector. A request on an enabled vector is latched as pending. The lowest-numbered pending vector that can be routed is offered on a delivery port, which carries its vector number, CPU index and pin number, and it stays there until it is acknowledged.

The route byte has two readings. In the compatible reading, which is the reset default, the high nibble names a node of four CPUs and the low nibble is a one-hot mask of the CPU inside that node. In the extended reading, the whole byte is a binary CPU number from 0 to 255. The pin selector has two readings in the same way: a one-hot mask of pins 0 to 3, or a binary pin number from 0 to 15. A read-only capability word advertises which readings exist. A read-write mode word selects between them at run time.

Software reaches all state through a 32-bit register port that uses word addresses and byte strobes. To change a route safely, software disables the vector, rewrites that vector's byte in the shared route word, and then enables the vector again.

Top module: `irq_route_ctrl`

Register map (word addresses):
- 0x00: capability word, read-only.
- 0x01: mode word.
- 0x10+g: enable word for group g, where g = vector >> 5.
- 0x18+g: pin selector for group g, held in bits [3:0].
- 0x40+w: route word, where w = vector >> 2. The vector's byte sits at bits [8*(vector mod 4) +: 8].

Delivery state machine:
- States: `ST_IDLE` (nothing offered) and `ST_OFFER` (a vector is held on the delivery port).
- Transition CAPTURE (`ST_IDLE` to `ST_OFFER`): taken when a routable pending vector exists. The vector, CPU and pin are registered on this transition.
- Transition RETIRE (`ST_OFFER` to `ST_IDLE`): taken on `dlv_ack`. It clears the offered vector's pending bit.

## Requirements
- R1: After reset, the following all read zero: the mode word, every enable word, every route word and every pin selector. `dlv_valid` is low.
- R2: The capability word reads the `CAPS` parameter. Its bit meanings are: 0 = extension present, 1 = enable option present, 2 = binary pin supported, 3 = binary CPU supported. Writes to it have no effect.
- R3: Only mode bits 1 (enable), 2 (binary pin) and 3 (binary CPU) are writable, and only where the matching capability bit is 1. All other mode bits read 0.
- R4: The enable for vector v is bit v mod 32 of enable word v >> 5. A request raised and dropped while its vector is disabled never becomes pending.
- R5: The route byte of vector v is lane v mod 4 of route word v >> 2. A write with byte strobes changes only the strobed lanes.
- R6: With mode bit 3 clear, the CPU index is node*4 + (lowest set bit of the low nibble), where node = route[7:4]. A route with an empty low nibble is not delivered.
- R7: With mode bit 3 set, the CPU index equals the 8-bit route byte.
- R8: With mode bit 2 clear, the pin is the lowest set bit of the group's selector, and an empty selector blocks delivery. With mode bit 2 set, the pin equals the 4-bit selector.
- R9: Among routable pending vectors, the lowest-numbered vector is offered first.
- R10: While `dlv_valid` is high and `dlv_ack` is low, the vector, CPU and pin hold steady. An acknowledge clears that vector's pending bit.
- R11: A single-cycle request on an enabled vector stays pending until it is delivered.
- R12: A vector that is pending but disabled is not offered. Once it is enabled again, it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_VEC | Level interrupt requests, one per vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte strobes for writes |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dlv_valid | output | 1 | A vector is being offered |
| dlv_vec | output | VEC_W | Offered vector number |
| dlv_cpu | output | 8 | Target CPU index |
| dlv_pin | output | 4 | Target CPU interrupt pin |
| dlv_ack | input | 1 | Acknowledge of the offered vector |

## Verification
The bench routes one vector through each mode combination:
- Compatible CPU reading with a multi-bit node mask, which shows that the node-times-four arithmetic and the lowest-bit choice are both correct.
- An empty CPU mask and an empty pin mask, which separate the two blocking conditions from each other.
- Binary CPU readings and binary pin readings, which show that the mode bit changes the decode of unchanged stored bytes.

Two vectors are then raised in the same cycle to show the priority order. The bench also drops the enable of a pending vector while another vector is held on the port. This tells masking of delivery apart from masking of capture. A request raised only while its vector is disabled shows that no pending bit leaks through.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } dlv_state_e;

    // mode word bit positions (software decodes these)
    localparam int MODE_ENABLE  = 1;
    localparam int MODE_PIN_BIN = 2;
    localparam int MODE_CPU_BIN = 3;

    // returns {routable, cpu[7:0]}
    function automatic logic [8:0] cpu_decode(input logic [7:0] rb, input logic bin);
        logic [1:0] core;
        logic [8:0] res;
        core = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (rb[i]) core = i[1:0];
        end
        if (bin) res = {1'b1, rb};
        else     res = {|rb[3:0], 2'b00, rb[7:4], core};
        return res;
    endfunction

    // returns {routable, pin[3:0]}
    function automatic logic [4:0] pin_decode(input logic [3:0] sel, input logic bin);
        logic [3:0] pin;
        logic [4:0] res;
        pin = 4'd0;
        for (int i = 3; i >= 0; i--) begin
            if (sel[i]) pin = i[3:0];
        end
        if (bin) res = {1'b1, sel};
        else     res = {|sel, pin};
        return res;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int          NUM_VEC = 256,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] CAPS    = 32'h0000_000F
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic [3:0]                reg_wstrb,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [NUM_VEC-1:0]        en_vec,
    output logic [NUM_VEC*8-1:0]      route_flat,
    output logic [(NUM_VEC/32)*4-1:0] pin_flat,
    output logic                      cpu_bin,
    output logic                      pin_bin
);
    localparam int GROUPS  = NUM_VEC / 32;
    localparam int RWORDS  = NUM_VEC / 4;
    localparam int A_CAPS  = 0;
    localparam int A_MODE  = 1;
    localparam int A_EN    = 16;
    localparam int A_PIN   = A_EN + 8;
    localparam int A_ROUTE = 64;
    localparam logic [DATA_W-1:0] MODE_MASK = CAPS & 32'h0000_000E;

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] en_q  [GROUPS];
    logic [3:0]        pin_q [GROUPS];
    logic [7:0]        rt_q  [NUM_VEC];
    logic [DATA_W-1:0] wm;

    assign wm = {{8{reg_wstrb[3]}}, {8{reg_wstrb[2]}}, {8{reg_wstrb[1]}}, {8{reg_wstrb[0]}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            for (int g = 0; g < GROUPS; g++) begin
                en_q[g]  <= '0;
                pin_q[g] <= '0;
            end
            for (int v = 0; v < NUM_VEC; v++) rt_q[v] <= '0;
        end else if (reg_wr) begin
            if (int'(reg_addr) == A_MODE)
                mode_q <= (mode_q & ~wm) | (reg_wdata & wm & MODE_MASK);
            for (int g = 0; g < GROUPS; g++) begin
                if (int'(reg_addr) == A_EN + g)
                    en_q[g] <= (en_q[g] & ~wm) | (reg_wdata & wm);
                if (int'(reg_addr) == A_PIN + g && reg_wstrb[0])
                    pin_q[g] <= reg_wdata[3:0];
            end
            for (int v = 0; v < NUM_VEC; v++) begin
                if (int'(reg_addr) == A_ROUTE + v / 4 && reg_wstrb[v % 4])
                    rt_q[v] <= reg_wdata[8*(v%4) +: 8];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == A_CAPS) reg_rdata = CAPS;
        if (int'(reg_addr) == A_MODE) reg_rdata = mode_q;
        for (int g = 0; g < GROUPS; g++) begin
            if (int'(reg_addr) == A_EN + g)  reg_rdata = en_q[g];
            if (int'(reg_addr) == A_PIN + g) reg_rdata = {28'd0, pin_q[g]};
        end
        for (int w = 0; w < RWORDS; w++) begin
            if (int'(reg_addr) == A_ROUTE + w)
                reg_rdata = {rt_q[4*w+3], rt_q[4*w+2], rt_q[4*w+1], rt_q[4*w]};
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign en_vec[32*g +: 32] = en_q[g];
        assign pin_flat[4*g +: 4] = pin_q[g];
    end
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_rt
        assign route_flat[8*v +: 8] = rt_q[v];
    end

    assign cpu_bin = mode_q[MODE_CPU_BIN];
    assign pin_bin = mode_q[MODE_PIN_BIN];

endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_VEC-1:0]        irq_in,
    input  logic [NUM_VEC-1:0]        en_vec,
    input  logic [NUM_VEC*8-1:0]      route_flat,
    input  logic [(NUM_VEC/32)*4-1:0] pin_flat,
    input  logic                      cpu_bin,
    input  logic                      pin_bin,
    input  logic                      clr_en,
    input  logic [VEC_W-1:0]          clr_vec,
    output logic                      found,
    output logic [VEC_W-1:0]          pick_vec,
    output logic [7:0]                pick_cpu,
    output logic [3:0]                pick_pin
);
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] routable;
    logic [NUM_VEC-1:0] cand;
    logic [7:0]         cpu_arr [NUM_VEC];
    logic [3:0]         pin_arr [NUM_VEC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (clr_en && int'(clr_vec) == v) pend_q[v] <= 1'b0;
                else if (irq_in[v] && en_vec[v])  pend_q[v] <= 1'b1;
            end
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
        logic [8:0] cd;
        logic [4:0] pd;
        assign cd          = cpu_decode(route_flat[8*v +: 8], cpu_bin);
        assign pd          = pin_decode(pin_flat[4*(v/32) +: 4], pin_bin);
        assign routable[v] = cd[8] & pd[4];
        assign cpu_arr[v]  = cd[7:0];
        assign pin_arr[v]  = pd[3:0];
    end

    assign cand = pend_q & en_vec & routable;

    always_comb begin
        found    = 1'b0;
        pick_vec = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (cand[v]) begin
                found    = 1'b1;
                pick_vec = v[VEC_W-1:0];
            end
        end
    end

    assign pick_cpu = cpu_arr[pick_vec];
    assign pick_pin = pin_arr[pick_vec];

    // R4: a newly pending bit must come from a vector that was enabled
    a_r4_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(en_vec)) == '0);

    // R10: the acknowledged vector is no longer pending afterwards
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !pend_q[$past(clr_vec)]);

    // R9: nothing below the chosen vector is a candidate
    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (cand & ~({NUM_VEC{1'b1}} << pick_vec)) == '0);

endmodule

// File: rtl/irq_route_deliver.sv
module irq_route_deliver
    import irq_route_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             found,
    input  logic [VEC_W-1:0] pick_vec,
    input  logic [7:0]       pick_cpu,
    input  logic [3:0]       pick_pin,
    input  logic             dlv_ack,
    output logic             dlv_valid,
    output logic [VEC_W-1:0] dlv_vec,
    output logic [7:0]       dlv_cpu,
    output logic [3:0]       dlv_pin,
    output logic             clr_en
);
    dlv_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (found)   state_d = ST_OFFER;  // CAPTURE
            ST_OFFER: if (dlv_ack) state_d = ST_IDLE;   // RETIRE
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_vec <= '0;
            dlv_cpu <= '0;
            dlv_pin <= '0;
        end else if (state_q == ST_IDLE && found) begin
            dlv_vec <= pick_vec;
            dlv_cpu <= pick_cpu;
            dlv_pin <= pick_pin;
        end
    end

    assign dlv_valid = (state_q == ST_OFFER);
    assign clr_en    = (state_q == ST_OFFER) && dlv_ack;

    // R10: offer is held steady until acknowledged
    a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ack) |=> (dlv_valid && $stable(dlv_vec)
                                     && $stable(dlv_cpu) && $stable(dlv_pin)));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int          NUM_VEC = 256,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] CAPS    = 32'h0000_000F,
    localparam int         VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic [3:0]         reg_wstrb,
    output logic [31:0]        reg_rdata,
    output logic               dlv_valid,
    output logic [VEC_W-1:0]   dlv_vec,
    output logic [7:0]         dlv_cpu,
    output logic [3:0]         dlv_pin,
    input  logic               dlv_ack
);
    logic [NUM_VEC-1:0]        en_vec;
    logic [NUM_VEC*8-1:0]      route_flat;
    logic [(NUM_VEC/32)*4-1:0] pin_flat;
    logic                      cpu_bin, pin_bin, found, clr_en;
    logic [VEC_W-1:0]          pick_vec;
    logic [7:0]                pick_cpu;
    logic [3:0]                pick_pin;

    irq_route_regs #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .CAPS(CAPS)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_wstrb, .reg_rdata,
        .en_vec, .route_flat, .pin_flat, .cpu_bin, .pin_bin
    );

    irq_route_pick #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pick (
        .clk, .rst_n, .irq_in, .en_vec, .route_flat, .pin_flat, .cpu_bin, .pin_bin,
        .clr_en, .clr_vec(dlv_vec), .found, .pick_vec, .pick_cpu, .pick_pin
    );

    irq_route_deliver #(.VEC_W(VEC_W)) u_dlv (
        .clk, .rst_n, .found, .pick_vec, .pick_cpu, .pick_pin, .dlv_ack,
        .dlv_valid, .dlv_vec, .dlv_cpu, .dlv_pin, .clr_en
    );

endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] irq_in = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [3:0]   reg_wstrb = '0;
    logic [31:0]  reg_rdata;
    logic         dlv_valid;
    logic [7:0]   dlv_vec;
    logic [7:0]   dlv_cpu;
    logic [3:0]   dlv_pin;
    logic         dlv_ack = 1'b0;
    int           n_chk = 0;
    int           n_bad = 0;
    int           cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_route_ctrl u_irq_route_ctrl (
        .clk, .rst_n, .irq_in, .reg_wr, .reg_addr, .reg_wdata, .reg_wstrb,
        .reg_rdata, .dlv_valid, .dlv_vec, .dlv_cpu, .dlv_pin, .dlv_ack
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles=%0d expected done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
        @(negedge clk);
        reg_wr = 1'b0; reg_wstrb = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        irq_in[v] = 1'b1;
        @(negedge clk);
        irq_in[v] = 1'b0;
    endtask

    task automatic wait_dlv(input int n, output bit got);
        got = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dlv_valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic expect_dlv(input string tag, input int v, input int c, input int p);
        bit got;
        wait_dlv(10, got);
        chk({tag, " valid"}, {31'd0, got}, 32'd1);
        chk({tag, " vec"}, {24'd0, dlv_vec}, v);
        chk({tag, " cpu"}, {24'd0, dlv_cpu}, c);
        chk({tag, " pin"}, {28'd0, dlv_pin}, p);
    endtask

    task automatic expect_none(input string tag);
        bit got;
        wait_dlv(10, got);
        chk(tag, {31'd0, got}, 32'd0);
    endtask

    task automatic ack();
        @(negedge clk);
        dlv_ack = 1'b1;
        @(negedge clk);
        dlv_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid at reset", {31'd0, dlv_valid}, 32'd0);
        rd_chk("R1 mode reset", 8'h01, 32'd0);
        rd_chk("R1 enable reset", 8'h10, 32'd0);
        rd_chk("R1 route reset", 8'h41, 32'd0);
        rd_chk("R1 pin reset", 8'h18, 32'd0);
    endtask

    task automatic t_caps_mode();
        rd_chk("R2 caps", 8'h00, 32'h0000_000F);
        wr(8'h00, 32'h0, 4'hF);
        rd_chk("R2 caps after write", 8'h00, 32'h0000_000F);
        wr(8'h01, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R3 mode writable bits", 8'h01, 32'h0000_000E);
        wr(8'h01, 32'h0, 4'hF);
    endtask

    task automatic t_legacy();
        wr(8'h41, 32'hAABB_CCDD, 4'hF);
        wr(8'h41, 32'h0000_3600, 4'b0010);
        rd_chk("R5 strobe keeps other lanes", 8'h41, 32'hAABB_36DD);
        wr(8'h18, 32'h0000_000C, 4'hF);
        wr(8'h10, 32'h0000_0020, 4'hF);
        rd_chk("R4 enable word readback", 8'h10, 32'h0000_0020);
        @(negedge clk); irq_in[5] = 1'b1;
        expect_dlv("R6 R8 legacy node/mask", 5, 13, 2);
        irq_in[5] = 1'b0;
        ack();
        expect_none("R10 no offer after ack");
    endtask

    task automatic t_empty_masks();
        wr(8'h19, 32'h1, 4'hF);
        wr(8'h4A, 32'h0000_0020, 4'b0001);
        wr(8'h11, 32'h0000_0100, 4'hF);
        pulse(40);
        expect_none("R6 empty cpu mask blocks");
        wr(8'h01, 32'h8, 4'hF);
        expect_dlv("R7 R11 binary cpu from latched pulse", 40, 32, 0);
        ack();
        wr(8'h19, 32'h0, 4'hF);
        pulse(40);
        expect_none("R8 empty pin mask blocks");
        wr(8'h01, 32'hC, 4'hF);
        expect_dlv("R8 binary pin zero", 40, 32, 0);
        ack();
        wr(8'h19, 32'hB, 4'hF);
        wr(8'h4A, 32'h0000_00C8, 4'b0001);
        pulse(40);
        expect_dlv("R7 R8 binary cpu and pin", 40, 200, 11);
        ack();
    endtask

    task automatic t_disabled_req();
        wr(8'h01, 32'h8, 4'hF);
        wr(8'h1B, 32'h1, 4'hF);
        @(negedge clk); irq_in[100] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[100] = 1'b0;
        wr(8'h13, 32'h0000_0010, 4'hF);
        expect_none("R4 request while disabled not latched");
    endtask

    task automatic t_priority_mask();
        wr(8'h7E, 32'h0007_0000, 4'b0100);
        wr(8'h1F, 32'h2, 4'hF);
        wr(8'h17, 32'h0400_0000, 4'hF);
        @(negedge clk); irq_in[40] = 1'b1; irq_in[250] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0; irq_in[250] = 1'b0;
        expect_dlv("R9 lower vector first", 40, 200, 0);
        repeat (5) @(negedge clk);
        chk("R10 held valid", {31'd0, dlv_valid}, 32'd1);
        chk("R10 held vec", {24'd0, dlv_vec}, 32'd40);
        chk("R10 held cpu", {24'd0, dlv_cpu}, 32'd200);
        wr(8'h17, 32'h0, 4'hF);
        ack();
        expect_none("R12 disabled pending not offered");
        wr(8'h17, 32'h0400_0000, 4'hF);
        expect_dlv("R12 R11 offered after re-enable", 250, 7, 1);
        ack();
        expect_none("R10 pending cleared by ack");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_caps_mode();
        t_legacy();
        t_empty_masks();
        t_disabled_req();
        t_priority_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule